// File: doc/BRIEF.md
# Register-Selected Clock Source Multiplexer

This block routes exactly one of up to eight parent clocks to a single output clock. The choice comes from a small select field inside a 32-bit control word written on the control clock. The output is the chosen parent itself: it is never gated, divided or multiplied. Parameters set where the field sits in the word and how its value is read. In zero-based mode the value is the parent index. In one-based mode the value is the index plus one, and zero is illegal. An optional commit bit makes a write take effect only when that bit is set in the same word.

A switchover never glitches. Each parent has its own enable chain clocked by that parent: two synchronizing flops, then a flop on the falling edge. A parent may turn on only after every other enable has dropped. The control domain serializes changes. A newly committed index waits in a pending register until the previous switchover is complete, and the last commit wins. An illegal value leaves the selection untouched and sets a sticky error flag. A status output reports the parent that is actually driving the output, once its switchover has finished.

Top module: `clk_src_mux`

## Requirements
- R1: In zero-based mode a field value v selects parent v; values of N_SRC or more are illegal.
- R2: In one-based mode a field value v selects parent v-1; zero and values above N_SRC are illegal.
- R3: The select field occupies cfg_wdata[SHIFT+SEL_W-1:SHIFT]; no other bit except the commit bit influences the selection.
- R4: With USE_LATCH set, a write changes the selection only if cfg_wdata[LATCH_BIT] is 1; a write with that bit at 0 has no effect on the output or the status.
- R5: A committed illegal value leaves the selection unchanged and sets sel_err, which then stays 1 until reset.
- R6: At most one parent enable is on at any time, and after a switchover clk_out has exactly the period of the selected parent.
- R7: After reset clk_out follows parent 0, active_idx is 0 and sel_err is 0.
- R8: active_idx changes only to the index whose switchover has just completed, and it always names an existing parent.
- R9: A commit that arrives while a switchover is in progress is held and applied after that switchover completes; of several such commits the last one determines the final parent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock for writes and status |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_clk | input | N_SRC | Parent clocks, bit i is parent i |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word carrying the select field and commit bit |
| clk_out | output | 1 | Selected parent clock |
| active_idx | output | IDX_W | Parent currently driving clk_out |
| sel_err | output | 1 | Sticky flag for an illegal committed value |

## Verification
Two things can overlap: an accepted commit and a switchover that is still in progress. When they do, the new index must wait in the pending register and not redirect enable chains that are already in motion. The bench provokes this by issuing two commits on consecutive control cycles. It then expects the status to settle on the second index and clk_out to show that parent's period. An illegal commit that lands while a legal selection is active is also judged: the status and the output period must stay put, and the error flag must rise and stay set.

// File: rtl/csm_pkg.sv
package csm_pkg;
   // outcome of one control write
   typedef enum logic [1:0] {
      WR_NONE = 2'd0,   // no write this cycle
      WR_HOLD = 2'd1,   // write without commit bit, no effect
      WR_BAD  = 2'd2,   // committed but illegal value
      WR_TAKE = 2'd3    // committed, legal value
   } wr_kind_e;
endpackage

// File: rtl/csm_sel_decode.sv
module csm_sel_decode
   import csm_pkg::*;
#(
   parameter int N_SRC     = 4,
   parameter int SEL_W     = 3,
   parameter int SHIFT     = 8,
   parameter bit ONE_BASED = 1'b1,
   parameter bit USE_LATCH = 1'b1,
   parameter int LATCH_BIT = 31,
   localparam int IDX_W    = $clog2(N_SRC)
) (
   input  logic             cfg_we,
   input  logic [31:0]      cfg_wdata,
   output wr_kind_e         kind,
   output logic [IDX_W-1:0] idx
);
   localparam logic [SEL_W:0] LIMIT = (SEL_W+1)'(N_SRC);

   logic [SEL_W-1:0] field;
   logic [SEL_W-1:0] raw;
   logic             legal;
   logic             commit;

   assign field = cfg_wdata[SHIFT +: SEL_W];

   generate
      if (ONE_BASED) begin : g_one
         assign raw   = field - SEL_W'(1);
         assign legal = (field != '0) && ({1'b0, raw} < LIMIT);
      end else begin : g_zero
         assign raw   = field;
         assign legal = {1'b0, raw} < LIMIT;
      end
      if (USE_LATCH) begin : g_latch
         assign commit = cfg_wdata[LATCH_BIT];
      end else begin : g_direct
         assign commit = 1'b1;
      end
   endgenerate

   assign idx = raw[IDX_W-1:0];

   always_comb begin
      if (!cfg_we)      kind = WR_NONE;
      else if (!commit) kind = WR_HOLD;
      else if (!legal)  kind = WR_BAD;
      else              kind = WR_TAKE;
   end
endmodule

// File: rtl/csm_src_gate.sv
module csm_src_gate #(
   parameter bit ON_AT_RESET = 1'b0
) (
   input  logic src_clk,
   input  logic rst_n,
   input  logic want,
   input  logic others_on,
   output logic en
);
   logic d;
   logic s1, s2;

   assign d = want & ~others_on;

   always_ff @(posedge src_clk or negedge rst_n) begin
      if (!rst_n) begin
         s1 <= ON_AT_RESET;
         s2 <= ON_AT_RESET;
      end else begin
         s1 <= d;
         s2 <= s1;
      end
   end

   // enable moves only while the source is low
   always_ff @(negedge src_clk or negedge rst_n) begin
      if (!rst_n) en <= ON_AT_RESET;
      else        en <= s2;
   end
endmodule

// File: rtl/csm_ctrl.sv
module csm_ctrl
   import csm_pkg::*;
#(
   parameter int N_SRC  = 4,
   localparam int IDX_W = $clog2(N_SRC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  wr_kind_e         kind,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [N_SRC-1:0] en_vec,
   output logic [IDX_W-1:0] tgt_idx,
   output logic [IDX_W-1:0] pend_idx,
   output logic [IDX_W-1:0] active_idx,
   output logic             sel_err
);
   localparam logic [N_SRC-1:0] EN_RST = N_SRC'(1);

   logic [N_SRC-1:0] en_m, en_s;
   logic             done;

   assign done = (en_s == (N_SRC'(1) << tgt_idx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_m       <= EN_RST;
         en_s       <= EN_RST;
         pend_idx   <= '0;
         tgt_idx    <= '0;
         active_idx <= '0;
         sel_err    <= 1'b0;
      end else begin
         en_m <= en_vec;
         en_s <= en_m;
         if (kind == WR_TAKE) pend_idx <= wr_idx;
         if (kind == WR_BAD)  sel_err  <= 1'b1;
         if (done) begin
            active_idx <= tgt_idx;
            if (pend_idx != tgt_idx) tgt_idx <= pend_idx;
         end
      end
   end
endmodule

// File: rtl/clk_src_mux.sv
module clk_src_mux
   import csm_pkg::*;
#(
   parameter int N_SRC     = 4,
   parameter int SEL_W     = 3,
   parameter int SHIFT     = 8,
   parameter bit ONE_BASED = 1'b1,
   parameter bit USE_LATCH = 1'b1,
   parameter int LATCH_BIT = 31,
   localparam int IDX_W    = $clog2(N_SRC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_clk,
   input  logic             cfg_we,
   input  logic [31:0]      cfg_wdata,
   output logic             clk_out,
   output logic [IDX_W-1:0] active_idx,
   output logic             sel_err
);
   generate
      if (N_SRC < 2 || N_SRC > 8) begin : g_bad_n
         $error("N_SRC must lie in 2..8");
      end
      if (SHIFT < 0 || SHIFT + SEL_W > 32) begin : g_bad_shift
         $error("select field does not fit the control word");
      end
      if (N_SRC + int'(ONE_BASED) > (1 << SEL_W) || SEL_W < IDX_W) begin : g_bad_w
         $error("SEL_W too narrow for N_SRC");
      end
      if (USE_LATCH && LATCH_BIT >= SHIFT && LATCH_BIT < SHIFT + SEL_W) begin : g_bad_l
         $error("commit bit overlaps the select field");
      end
   endgenerate

   wr_kind_e         kind;
   logic [IDX_W-1:0] wr_idx;
   logic [IDX_W-1:0] tgt_idx;
   logic [IDX_W-1:0] pend_idx;
   logic [N_SRC-1:0] en_vec;
   logic [N_SRC-1:0] want_vec;

   csm_sel_decode #(
      .N_SRC(N_SRC), .SEL_W(SEL_W), .SHIFT(SHIFT),
      .ONE_BASED(ONE_BASED), .USE_LATCH(USE_LATCH), .LATCH_BIT(LATCH_BIT)
   ) u_dec (
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .kind(kind), .idx(wr_idx)
   );

   csm_ctrl #(.N_SRC(N_SRC)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .kind(kind), .wr_idx(wr_idx),
      .en_vec(en_vec), .tgt_idx(tgt_idx), .pend_idx(pend_idx),
      .active_idx(active_idx), .sel_err(sel_err)
   );

   assign want_vec = N_SRC'(1) << tgt_idx;

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      localparam logic [N_SRC-1:0] OTHERS = ~(N_SRC'(1) << i);
      csm_src_gate #(.ON_AT_RESET(i == 0)) u_gate (
         .src_clk(src_clk[i]), .rst_n(rst_n), .want(want_vec[i]),
         .others_on(|(en_vec & OTHERS)), .en(en_vec[i])
      );
   end

   assign clk_out = |(src_clk & en_vec);
endmodule

// File: rtl/csm_checker.sv
module csm_checker #(
   parameter int N_SRC     = 4,
   parameter int SEL_W     = 3,
   parameter int SHIFT     = 8,
   parameter bit ONE_BASED = 1'b1,
   parameter bit USE_LATCH = 1'b1,
   parameter int LATCH_BIT = 31,
   localparam int IDX_W    = $clog2(N_SRC)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic [31:0]      cfg_wdata,
   input logic [N_SRC-1:0] en_vec,
   input logic [IDX_W-1:0] tgt_idx,
   input logic [IDX_W-1:0] pend_idx,
   input logic [IDX_W-1:0] active_idx,
   input logic             sel_err
);
   int   fval;
   logic ok_val, committed, bad_wr, hold_wr;

   assign fval      = int'(cfg_wdata[SHIFT +: SEL_W]);
   assign ok_val    = ONE_BASED ? (fval >= 1 && fval <= N_SRC) : (fval < N_SRC);
   assign committed = cfg_we && (!USE_LATCH || cfg_wdata[LATCH_BIT]);
   assign bad_wr    = committed && !ok_val;
   assign hold_wr   = cfg_we && USE_LATCH && !cfg_wdata[LATCH_BIT];

   assert_one_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(en_vec));
   assert_bad_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bad_wr |=> sel_err);
   assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sel_err |=> sel_err);
   assert_bad_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bad_wr |=> $stable(pend_idx));
   assert_hold_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hold_wr |=> $stable(pend_idx));
   assert_status_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      int'(active_idx) < N_SRC);
   assert_status_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(active_idx) |-> active_idx == $past(tgt_idx));
endmodule

bind clk_src_mux csm_checker #(
   .N_SRC(N_SRC), .SEL_W(SEL_W), .SHIFT(SHIFT),
   .ONE_BASED(ONE_BASED), .USE_LATCH(USE_LATCH), .LATCH_BIT(LATCH_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
   .en_vec(en_vec), .tgt_idx(tgt_idx), .pend_idx(pend_idx),
   .active_idx(active_idx), .sel_err(sel_err)
);

// File: tb/clk_src_mux_tb_top.sv
`timescale 1ns/1ps
module clk_src_mux_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic s0 = 1'b0, s1 = 1'b0, s2 = 1'b0, s3 = 1'b0;
   logic [3:0] src4;
   logic [2:0] src3;

   // one-based, field at bit 8, commit bit 31
   logic        we_a = 1'b0;
   logic [31:0] wd_a = '0;
   logic        out_a, err_a;
   logic [1:0]  act_a;
   // zero-based, field at bit 0, no commit bit, three parents
   logic        we_b = 1'b0;
   logic [31:0] wd_b = '0;
   logic        out_b, err_b;
   logic [1:0]  act_b;

   int n_cmp = 0;
   int n_bad = 0;

   typedef struct {
      int    dut;
      int    idx;
      int    err;
      int    per10;
      string tag;
   } exp_t;
   exp_t sbq[$];

   always #5 clk = ~clk;
   always #4  s0 = ~s0;   // period 8
   always #7  s1 = ~s1;   // period 14
   always #10 s2 = ~s2;   // period 20
   always #13 s3 = ~s3;   // period 26
   assign src4 = {s3, s2, s1, s0};
   assign src3 = {s2, s1, s0};

   clk_src_mux #(.N_SRC(4), .SEL_W(3), .SHIFT(8), .ONE_BASED(1'b1),
                 .USE_LATCH(1'b1), .LATCH_BIT(31)) dut_i (
      .clk(clk), .rst_n(rst_n), .src_clk(src4), .cfg_we(we_a), .cfg_wdata(wd_a),
      .clk_out(out_a), .active_idx(act_a), .sel_err(err_a));

   clk_src_mux #(.N_SRC(3), .SEL_W(2), .SHIFT(0), .ONE_BASED(1'b0),
                 .USE_LATCH(1'b0), .LATCH_BIT(31)) dut_zb (
      .clk(clk), .rst_n(rst_n), .src_clk(src3), .cfg_we(we_b), .cfg_wdata(wd_b),
      .clk_out(out_b), .active_idx(act_b), .sel_err(err_b));

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   task automatic chk(string tag, string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic wr_a(int field, bit commit, logic [31:0] noise);
      @(negedge clk);
      we_a = 1'b1;
      wd_a = (noise & 32'h7FFF_F8FF) | (32'(field & 7) << 8) | (32'(commit) << 31);
      @(negedge clk);
      we_a = 1'b0;
      wd_a = '0;
   endtask

   task automatic wr_b(int field);
      @(negedge clk);
      we_b = 1'b1;
      wd_b = 32'(field & 3);
      @(negedge clk);
      we_b = 1'b0;
      wd_b = '0;
   endtask

   task automatic expect_item(int dut, int idx, int err, int per, string tag);
      exp_t e;
      e.dut = dut; e.idx = idx; e.err = err; e.per10 = per * 10; e.tag = tag;
      sbq.push_back(e);
      wait (sbq.size() == 0);
   endtask

   // monitor: let the switchover settle, then compare status, flag, period
   initial begin
      forever begin
         exp_t e;
         realtime t0, t1;
         wait (sbq.size() != 0);
         e = sbq[0];
         repeat (150) @(negedge clk);
         if (e.dut == 0) begin
            chk(e.tag, "active_idx", int'(act_a), e.idx);
            chk(e.tag, "sel_err", int'(err_a), e.err);
            @(posedge out_a); t0 = $realtime;
            @(posedge out_a); t1 = $realtime;
         end else begin
            chk(e.tag, "active_idx", int'(act_b), e.idx);
            chk(e.tag, "sel_err", int'(err_b), e.err);
            @(posedge out_b); t0 = $realtime;
            @(posedge out_b); t1 = $realtime;
         end
         chk(e.tag, "period_x10", $rtoi((t1 - t0) * 10.0 + 0.5), e.per10);
         void'(sbq.pop_front());
      end
   end

   initial begin
      #2_000_000;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R7: reset state on both instances
      expect_item(0, 0, 0, 8, "R7");
      expect_item(1, 0, 0, 8, "R7");
      // R2 + R4: committed one-based value 3 selects parent 2
      wr_a(3, 1'b1, 32'h0);
      expect_item(0, 2, 0, 20, "R2");
      // R4: write without commit bit leaves everything as is
      wr_a(1, 1'b0, 32'h0);
      expect_item(0, 2, 0, 20, "R4");
      // R5 + R2: zero is illegal in one-based mode
      wr_a(0, 1'b1, 32'h0);
      expect_item(0, 2, 1, 20, "R5");
      // R5: value past last parent is ignored, flag stays
      wr_a(5, 1'b1, 32'h0);
      expect_item(0, 2, 1, 20, "R5");
      // R6: back to parent 0, flag still sticky
      wr_a(1, 1'b1, 32'h0);
      expect_item(0, 0, 1, 8, "R6");
      wr_a(4, 1'b1, 32'h0);
      expect_item(0, 3, 1, 26, "R6");
      // R3: noise outside the field does not matter
      wr_a(2, 1'b1, 32'hFFFF_FFFF);
      expect_item(0, 1, 1, 14, "R3");
      // R9: second commit one cycle after the first wins
      @(negedge clk);
      we_a = 1'b1; wd_a = (32'd1 << 8) | (32'd1 << 31);
      @(negedge clk);
      wd_a = (32'd3 << 8) | (32'd1 << 31);
      @(negedge clk);
      we_a = 1'b0; wd_a = '0;
      expect_item(0, 2, 1, 20, "R9");
      // R1: zero-based instance, no commit bit needed
      wr_b(2);
      expect_item(1, 2, 0, 20, "R1");
      wr_b(3);
      expect_item(1, 2, 1, 20, "R1");
      wr_b(1);
      expect_item(1, 1, 1, 14, "R1");
      wr_b(0);
      expect_item(1, 0, 1, 8, "R1");
      summary();
      $finish;
   end
endmodule